// File: doc/BRIEF.md
# Page-Offset-Indexed, Physically-Tagged L1 Read Cache

This block is the read side of a level-one data cache that starts its array lookup before address translation has finished. The set index and word select come only from the low twelve address bits, which are identical in the virtual and the physical address. The tag and data arrays are therefore read in the same cycle in which the translation buffer delivers the physical page number. That page number, and the flag that says whether translation succeeded, are used only in the final tag compare. A hit, including selection of the requested word, is reported one cycle after the request is accepted.

Each way is exactly one 4 KB page deep: 128 sets of 32-byte lines. Capacity comes from a second way, which gives 8 KB. When the cache misses, the outside agent refills the line through a fill port. The fill writes the whole line and its physical tag into the way that the set's replacement bit names.

The request side is valid/ready. A request is taken on a rising edge when `req_valid` and `req_ready` are both high. `req_ready` drops in any cycle in which `fill_valid` is high, so a requester must hold its request until `req_ready` returns. A fill is always taken in the cycle `fill_valid` is high. The response is a one-cycle `rsp_valid` pulse with flags, and it cannot be back-pressured.

Top module: `vipt_l1_cache`

## Requirements
- R1: After reset every line is invalid, so the first lookup of any set with translation present reports a miss.
- R2: A request accepted at a clock edge gives `rsp_valid` high for exactly the following cycle. With no accepted request, `rsp_valid` is low.
- R3: The set index is `req_vaddr[11:5]` and the word select is `req_vaddr[4:2]`. Bits `[31:12]` and `[1:0]` of `req_vaddr` have no effect on the result.
- R4: With `req_tlb_hit` high, `rsp_hit` is raised when a valid way of the indexed set holds a tag equal to `req_ppn`. `rsp_data` is then word k of that line, where word k occupies line bits `[32k+31:32k]` and k is the word select.
- R5: With `req_tlb_hit` high and no matching valid way, `rsp_miss` is raised, `rsp_hit` stays low and `rsp_data` is zero.
- R6: With `req_tlb_hit` low, `rsp_stall` is raised, both `rsp_hit` and `rsp_miss` stay low, and the replacement bit of the set is unchanged.
- R7: A fill writes `fill_line` and `fill_ppn` into set `fill_index` of the way that the set's replacement bit names, and marks that line valid. Way 0 is named after reset.
- R8: The replacement bit of a set is updated on a hit and on a fill. In both cases it is set to name the way that was not used.
- R9: `req_ready` is low whenever `fill_valid` is high. A request offered in that cycle is not taken and gives no response.
- R10: Two different page numbers that map to the same set can be resident at the same time, one per way, so the cache holds 8 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Lookup can be taken this cycle |
| req_vaddr | input | 32 | Virtual address of the read |
| req_ppn | input | 20 | Physical page number from translation, same cycle |
| req_tlb_hit | input | 1 | Translation succeeded this cycle |
| fill_valid | input | 1 | Refill line present, always taken |
| fill_index | input | 7 | Set being refilled |
| fill_ppn | input | 20 | Physical tag of the refilled line |
| fill_line | input | 256 | Line data, word k at bits [32k+31:32k] |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed with translation present |
| rsp_stall | output | 1 | Translation absent, no cache outcome |
| rsp_data | output | 32 | Selected word on a hit, zero otherwise |

## Verification
The checks on the hit vector assume that a set never holds the same physical tag in both ways. They therefore rely on the outside agent to refill only after a miss for that tag. The stimulus fills a line only when the bench's own model reports that tag absent from the set. The assertions also take `req_tlb_hit` and `req_ppn` to be driven in the same cycle as the accepted request. The bench drives all request fields together on the falling edge. The index sweeps cover every set and every word select, with varied upper and byte-offset address bits, so the page-offset-only indexing is exercised across the whole array.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int ADDR_W      = 32;
  localparam int PAGE_BYTES  = 4096;
  localparam int CACHE_BYTES = 8192;
  localparam int LINE_BYTES  = 32;
  localparam int WORD_BYTES  = 4;

  localparam int PAGE_OFF_W  = $clog2(PAGE_BYTES);
  localparam int OFF_W       = $clog2(LINE_BYTES);
  localparam int WSEL_LSB    = $clog2(WORD_BYTES);
  localparam int WSEL_W      = OFF_W - WSEL_LSB;
  localparam int IDX_W       = PAGE_OFF_W - OFF_W;
  localparam int SETS        = 1 << IDX_W;
  localparam int TAG_W       = ADDR_W - PAGE_OFF_W;
  localparam int WAYS        = CACHE_BYTES / PAGE_BYTES;
  localparam int WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int WORD_W      = WORD_BYTES * 8;
  localparam int WORDS       = LINE_BYTES / WORD_BYTES;
  localparam int LINE_W      = LINE_BYTES * 8;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [WSEL_W-1:0] wsel_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/vipt_way.sv
module vipt_way
  import vipt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  idx_t  rd_idx,
  input  tag_t  rd_tag,
  output logic  rd_match,
  output line_t rd_line,
  input  logic  wr_en,
  input  idx_t  wr_idx,
  input  tag_t  wr_tag,
  input  line_t wr_line
);
  logic [SETS-1:0] valid_q;
  tag_t            tag_mem  [SETS];
  line_t           line_mem [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
  end

  always_comb begin
    rd_line  = line_mem[rd_idx];
    rd_match = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  end

  assert_fill_marks_valid_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

  assert_fill_tag_readable_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=> ($past(rd_idx) != rd_idx) || (rd_match == (rd_tag == $past(wr_tag))));
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru
  import vipt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_en,
  input  idx_t hit_idx,
  input  way_t hit_way,
  input  logic fill_en,
  input  idx_t fill_idx,
  output way_t victim
);
  way_t lru_q [SETS];

  function automatic way_t next_way(input way_t w);
    if (int'(w) == WAYS - 1) return '0;
    return w + way_t'(1);
  endfunction

  assign victim = lru_q[fill_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (fill_en) begin
      lru_q[fill_idx] <= next_way(lru_q[fill_idx]);
    end else if (hit_en) begin
      lru_q[hit_idx] <= next_way(hit_way);
    end
  end

  assert_hit_moves_lru_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (hit_en && !fill_en) |=> lru_q[$past(hit_idx)] != $past(hit_way));

  assert_fill_moves_lru_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    fill_en |=> lru_q[$past(fill_idx)] != $past(victim));
endmodule

// File: rtl/vipt_pick.sv
module vipt_pick
  import vipt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  match,
  input  line_t            lines [WAYS],
  input  wsel_t            wsel,
  output logic             any,
  output way_t             way,
  output word_t            word
);
  line_t sel_line;

  always_comb begin
    any      = 1'b0;
    way      = '0;
    sel_line = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w] && !any) begin
        any      = 1'b1;
        way      = way_t'(w);
        sel_line = lines[w];
      end
    end
    word = sel_line[int'(wsel)*WORD_W +: WORD_W];
  end

  assert_single_way_match_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/vipt_l1_cache.sv
module vipt_l1_cache
  import vipt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [TAG_W-1:0]    req_ppn,
  input  logic                req_tlb_hit,
  input  logic                fill_valid,
  input  logic [IDX_W-1:0]    fill_index,
  input  logic [TAG_W-1:0]    fill_ppn,
  input  logic [LINE_W-1:0]   fill_line,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_stall,
  output logic [WORD_W-1:0]   rsp_data
);
  idx_t            rd_idx;
  wsel_t           rd_wsel;
  logic [WAYS-1:0] way_match;
  line_t           way_line [WAYS];
  logic [WAYS-1:0] way_wr;
  way_t            victim;
  logic            any_match;
  way_t            match_way;
  word_t           match_word;
  logic            accept;
  logic            do_hit;

  assign rd_idx    = req_vaddr[PAGE_OFF_W-1:OFF_W];
  assign rd_wsel   = req_vaddr[OFF_W-1:WSEL_LSB];
  assign req_ready = !fill_valid;
  assign accept    = req_valid && req_ready;
  assign do_hit    = accept && req_tlb_hit && any_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_wr[w] = fill_valid && (victim == way_t'(w));
    vipt_way u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_tag   (req_ppn),
      .rd_match (way_match[w]),
      .rd_line  (way_line[w]),
      .wr_en    (way_wr[w]),
      .wr_idx   (fill_index),
      .wr_tag   (fill_ppn),
      .wr_line  (fill_line)
    );
  end

  vipt_pick u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .match (way_match),
    .lines (way_line),
    .wsel  (rd_wsel),
    .any   (any_match),
    .way   (match_way),
    .word  (match_word)
  );

  vipt_lru u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_en   (do_hit),
    .hit_idx  (rd_idx),
    .hit_way  (match_way),
    .fill_en  (fill_valid),
    .fill_idx (fill_index),
    .victim   (victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_stall <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= do_hit;
      rsp_miss  <= accept && req_tlb_hit && !any_match;
      rsp_stall <= accept && !req_tlb_hit;
      rsp_data  <= do_hit ? match_word : '0;
    end
  end

  assert_resp_follows_accept_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_resp_without_accept_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  assert_stall_only_untranslated_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_tlb_hit) |=> (rsp_stall && !rsp_hit && !rsp_miss));

  assert_miss_data_zero_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_data == '0 && !rsp_hit));

  assert_fill_blocks_request_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    fill_valid |=> !rsp_valid);
endmodule

// File: tb/vipt_l1_cache_bench.sv
module vipt_l1_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_vaddr;
  logic [19:0]  req_ppn;
  logic         req_tlb_hit;
  logic         fill_valid;
  logic [6:0]   fill_index;
  logic [19:0]  fill_ppn;
  logic [255:0] fill_line;
  logic         rsp_valid, rsp_hit, rsp_miss, rsp_stall;
  logic [31:0]  rsp_data;

  int checks = 0;
  int errors = 0;

  logic [19:0] m_tag [2][128];
  logic        m_val [2][128];
  logic        m_lru [128];

  always #4 clk = ~clk;

  vipt_l1_cache u_vipt_l1_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ppn(req_ppn), .req_tlb_hit(req_tlb_hit),
    .fill_valid(fill_valid), .fill_index(fill_index), .fill_ppn(fill_ppn),
    .fill_line(fill_line), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_stall(rsp_stall), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] word_of(logic [19:0] tag, int set, int w);
    return {tag[19:0], 12'h000} ^ (32'(set) << 5) ^ (32'(w) << 2) ^ 32'h3;
  endfunction

  function automatic logic [255:0] line_of(logic [19:0] tag, int set);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = word_of(tag, set, w);
    return l;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_req(int set, int w, logic [19:0] ppn, bit tlb,
                        logic [19:0] hi, logic [1:0] lo, string req);
    int hw;
    bit exp_hit, exp_miss;
    logic [31:0] exp_data;
    hw = -1;
    req_valid   = 1'b1;
    req_vaddr   = {hi, 7'(set), 3'(w), lo};
    req_ppn     = ppn;
    req_tlb_hit = tlb;
    for (int k = 0; k < 2; k++)
      if (m_val[k][set] && m_tag[k][set] == ppn && hw < 0) hw = k;
    exp_hit  = tlb && hw >= 0;
    exp_miss = tlb && hw < 0;
    exp_data = exp_hit ? word_of(ppn, set, w) : 32'h0;
    if (exp_hit) m_lru[set] = (hw == 0);
    @(negedge clk);
    check(rsp_valid == 1'b1, req, "rsp_valid", 32'(rsp_valid), 32'h1);
    check(rsp_hit == exp_hit && rsp_miss == exp_miss && rsp_stall == !tlb, req,
          "hit/miss/stall", {29'h0, rsp_hit, rsp_miss, rsp_stall},
          {29'h0, exp_hit, exp_miss, !tlb});
    check(rsp_data == exp_data, req, "rsp_data", rsp_data, exp_data);
    req_valid = 1'b0;
  endtask

  task automatic do_fill(int set, logic [19:0] tag);
    int v;
    v = m_lru[set] ? 1 : 0;
    fill_valid = 1'b1;
    fill_index = 7'(set);
    fill_ppn   = tag;
    fill_line  = line_of(tag, set);
    m_tag[v][set] = tag;
    m_val[v][set] = 1'b1;
    m_lru[set]    = (v == 0);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_ppn = '0; req_tlb_hit = 1'b0;
    fill_valid = 1'b0; fill_index = '0; fill_ppn = '0; fill_line = '0;
    for (int s = 0; s < 128; s++) begin
      m_val[0][s] = 1'b0; m_val[1][s] = 1'b0; m_lru[s] = 1'b0;
      m_tag[0][s] = '0;   m_tag[1][s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: idle after reset, no response; R9: ready while no fill
    check(rsp_valid == 1'b0, "R2", "rsp_valid idle", 32'(rsp_valid), 32'h0);
    check(req_ready == 1'b1, "R9", "req_ready idle", 32'(req_ready), 32'h1);

    // R1: every set misses after reset
    for (int s = 0; s < 128; s++) do_req(s, s % 8, 20'hA1234, 1'b1, 20'(s * 977), 2'(s), "R1");

    // R7: fill every set with tag A, lands in way 0
    for (int s = 0; s < 128; s++) do_fill(s, 20'hA1234);

    // R3/R4: every set, every word, varied upper and byte bits
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 8; w++)
        do_req(s, w, 20'hA1234, 1'b1, 20'(s * 31 + w * 4099), 2'(w), "R4");

    // R5: different page number misses
    for (int s = 0; s < 128; s += 7) do_req(s, 3, 20'h0BEEF, 1'b1, 20'h0, 2'b0, "R5");

    // R6: untranslated access stalls
    for (int s = 0; s < 128; s += 5) do_req(s, 1, 20'hA1234, 1'b0, 20'hFFFFF, 2'b11, "R6");

    // R8/R10: second tag per set goes into the other way, both stay resident
    for (int s = 0; s < 128; s++) do_fill(s, 20'h0BEEF);
    for (int s = 0; s < 128; s++) begin
      do_req(s, 6, 20'hA1234, 1'b1, 20'h12345, 2'b01, "R10");
      do_req(s, 2, 20'h0BEEF, 1'b1, 20'h54321, 2'b10, "R10");
    end

    // R8: replace by recency; stall between must not disturb it (R6)
    for (int s = 0; s < 128; s += 9) begin
      do_req(s, 0, 20'hA1234, 1'b1, 20'h0, 2'b0, "R8");
      do_req(s, 0, 20'h0BEEF, 1'b0, 20'h0, 2'b0, "R6");
      do_fill(s, 20'h77777);
      do_req(s, 4, 20'h77777, 1'b1, 20'h3, 2'b0, "R7");
      do_req(s, 4, 20'hA1234, 1'b1, 20'h3, 2'b0, "R8");
      do_req(s, 4, 20'h0BEEF, 1'b1, 20'h3, 2'b0, "R8");
    end

    // R9: request offered during fill is not taken
    fill_valid = 1'b1; fill_index = 7'd100; fill_ppn = 20'h44444;
    fill_line = line_of(20'h44444, 100);
    m_tag[m_lru[100] ? 1 : 0][100] = 20'h44444;
    m_val[m_lru[100] ? 1 : 0][100] = 1'b1;
    m_lru[100] = !m_lru[100];
    req_valid = 1'b1; req_vaddr = {20'h0, 7'd100, 3'd0, 2'd0}; req_ppn = 20'h44444; req_tlb_hit = 1'b1;
    #1;
    check(req_ready == 1'b0, "R9", "req_ready during fill", 32'(req_ready), 32'h0);
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b0;
    check(rsp_valid == 1'b0, "R9", "no response for blocked request", 32'(rsp_valid), 32'h0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2", "rsp_valid single pulse", 32'(rsp_valid), 32'h0);
    do_req(100, 7, 20'h44444, 1'b1, 20'h0, 2'b0, "R7");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule